// File: doc/BRIEF.md
# Deferred Line-Configuration Shadow Registers

This block sits between a host configuration port and the live line-configuration registers of a serial transmitter. The host writes four configuration items into shadow copies: the mode/handshake byte, the port output byte, the data-format byte and a 10-bit baud divisor. A host write never reaches the live register directly. It only raises a single pending flag. The pending set is committed only while the transmitter reports that it is idle and ready for data, so a reconfiguration never lands in the middle of a character.

A commit first snapshots all shadows and drops the pending flag. It then loads the live registers one per cycle: mode, then port value, then data format, then the divisor. The divisor is split across two registers. Its low byte goes to the baud register. Its top two bits go into the top two bits of a second control register, whose low six bits are written directly by the host and are kept as they are during the commit. The transmit-break control is a bit of the data-format byte, so setting or clearing break also takes the deferred path.

Top module: `linecfg_defer`

## Requirements
- R1: After reset all live outputs (`mode_o`, `port_o`, `fmt_o`, `baud_o`, `ctl2_o`) are 0 and both `pending_o` and `busy_o` are 0.
- R2: A write with `wr_sel_i` equal to 0 (mode), 1 (port), 2 (format) or 3 (divisor) updates only the shadow and sets `pending_o` on the next cycle. No live output changes.
- R3: When `pending_o` is 1, `busy_o` is 0 and `tx_idle_i` is 1 at a clock edge, a commit starts at that edge. After that edge `busy_o` is 1 and `pending_o` is 0. A write made while the transmitter is already idle therefore starts its commit one cycle after the write.
- R4: A commit loads `mode_o` at the first edge after the start, `port_o` at the second, `fmt_o` at the third, and `baud_o` and `ctl2_o[7:6]` at the fourth. `busy_o` is high for exactly those four cycles.
- R5: The divisor commit sets `baud_o` to divisor bits 7:0 and `ctl2_o[7:6]` to divisor bits 9:8. It leaves `ctl2_o[5:0]` unchanged.
- R6: A write with `wr_sel_i` = 4 loads `wr_data_i[5:0]` into `ctl2_o[5:0]` at once. It keeps `ctl2_o[7:6]` and does not set `pending_o`.
- R7: `brk_wr_i` writes `brk_val_i` into bit 6 of the format shadow and sets `pending_o`. When it comes in the same cycle as a format write, the break value overrides bit 6 of the written byte.
- R8: When several writes reach the same shadow before a commit, only the latest value is committed.
- R9: A write accepted while a commit is in progress, including the cycle in which the commit starts, does not change the values that commit loads. It leaves `pending_o` at 1, and the next commit applies the new value.
- R10: While `tx_idle_i` is 0, no commit starts and the live outputs hold. Once `tx_idle_i` becomes 1, the pending set commits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Host write strobe |
| wr_sel_i | input | 3 | Target: 0 mode, 1 port, 2 format, 3 divisor, 4 control-2 low bits |
| wr_data_i | input | 10 | Write data (byte targets use bits 7:0, control-2 uses bits 5:0) |
| brk_wr_i | input | 1 | Update the break bit of the format shadow |
| brk_val_i | input | 1 | New break bit value |
| tx_idle_i | input | 1 | Transmitter idle and ready for data |
| mode_o | output | 8 | Live mode/handshake register |
| port_o | output | 8 | Live port output value |
| fmt_o | output | 8 | Live data-format register (bit 6 = transmit break) |
| baud_o | output | 8 | Live baud register (divisor bits 7:0) |
| ctl2_o | output | 8 | Live control-2 register (7:6 divisor bits 9:8, 5:0 host) |
| pending_o | output | 1 | Shadow changes not yet committed |
| busy_o | output | 1 | Commit sequence in progress |

## Verification
A host write and the start of a commit can fall on the same clock edge. In that case the write must land in the shadow and keep the pending flag set, and the commit in flight must load the older snapshot. The bench provokes this with two back-to-back mode writes while the transmitter is idle, so that the second write meets the start edge. It checks that `pending_o` stays 1 during the commit, that the first commit shows the first value, and that a second commit follows and shows the second value. A port write made in the middle of that commit is judged the same way. A host write to the control-2 low bits against the divisor commit is covered by checking that the divisor commit keeps those bits.

// File: rtl/lcfg_pkg.sv
package lcfg_pkg;
  typedef enum logic [2:0] {
    SEL_MODE = 3'd0,
    SEL_PORT = 3'd1,
    SEL_FMT  = 3'd2,
    SEL_DIV  = 3'd3,
    SEL_CTL2 = 3'd4
  } sel_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_MODE = 3'd1,
    ST_PORT = 3'd2,
    ST_FMT  = 3'd3,
    ST_DIV  = 3'd4
  } cst_e;

  localparam int unsigned NUM_BYTE_REGS = 3;
endpackage

// File: rtl/lcfg_shadow_bank.sv
module lcfg_shadow_bank
  import lcfg_pkg::*;
#(
  parameter int unsigned REG_W   = 8,
  parameter int unsigned DIV_W   = 10,
  parameter int unsigned BRK_BIT = 6
) (
  input  logic                                    clk_i,
  input  logic                                    rst_ni,
  input  logic                                    wr_en_i,
  input  logic [2:0]                              wr_sel_i,
  input  logic [DIV_W-1:0]                        wr_data_i,
  input  logic                                    brk_wr_i,
  input  logic                                    brk_val_i,
  input  logic                                    commit_start_i,
  output logic [NUM_BYTE_REGS-1:0][REG_W-1:0]     sh_byte_o,
  output logic [DIV_W-1:0]                        sh_div_o,
  output logic                                    pend_o
);
  logic [NUM_BYTE_REGS-1:0] byte_hit;
  logic                     div_hit;
  logic                     defer_wr;

  // byte shadows are indexed by their select code
  for (genvar g = 0; g < NUM_BYTE_REGS; g++) begin : g_byte
    assign byte_hit[g] = wr_en_i && (wr_sel_i == 3'(g));

    if (g == int'(SEL_FMT)) begin : g_fmt
      logic [REG_W-1:0] nxt;
      always_comb begin
        nxt = byte_hit[g] ? wr_data_i[REG_W-1:0] : sh_byte_o[g];
        if (brk_wr_i) nxt[BRK_BIT] = brk_val_i;
      end
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sh_byte_o[g] <= '0;
        else         sh_byte_o[g] <= nxt;
      end
    end else begin : g_plain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)          sh_byte_o[g] <= '0;
        else if (byte_hit[g]) sh_byte_o[g] <= wr_data_i[REG_W-1:0];
      end
    end
  end

  assign div_hit  = wr_en_i && (wr_sel_i == SEL_DIV);
  assign defer_wr = (|byte_hit) || div_hit || brk_wr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sh_div_o <= '0;
    else if (div_hit) sh_div_o <= wr_data_i;
  end

  // a write in the start cycle wins over the clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             pend_o <= 1'b0;
    else if (defer_wr)       pend_o <= 1'b1;
    else if (commit_start_i) pend_o <= 1'b0;
  end
endmodule

// File: rtl/lcfg_commit_seq.sv
module lcfg_commit_seq
  import lcfg_pkg::*;
#(
  parameter int unsigned REG_W = 8,
  parameter int unsigned DIV_W = 10
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                pend_i,
  input  logic                                tx_idle_i,
  input  logic [NUM_BYTE_REGS-1:0][REG_W-1:0] sh_byte_i,
  input  logic [DIV_W-1:0]                    sh_div_i,
  output logic                                commit_start_o,
  output logic [NUM_BYTE_REGS-1:0]            ld_byte_o,
  output logic                                ld_div_o,
  output logic [NUM_BYTE_REGS-1:0][REG_W-1:0] stg_byte_o,
  output logic [DIV_W-1:0]                    stg_div_o,
  output logic                                busy_o
);
  cst_e st_q, st_d;

  assign commit_start_o = (st_q == ST_IDLE) && pend_i && tx_idle_i;

  always_comb begin
    unique case (st_q)
      ST_IDLE: st_d = commit_start_o ? ST_MODE : ST_IDLE;
      ST_MODE: st_d = ST_PORT;
      ST_PORT: st_d = ST_FMT;
      ST_FMT:  st_d = ST_DIV;
      ST_DIV:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  // snapshot keeps a commit atomic against writes during the sequence
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_byte_o <= '0;
      stg_div_o  <= '0;
    end else if (commit_start_o) begin
      stg_byte_o <= sh_byte_i;
      stg_div_o  <= sh_div_i;
    end
  end

  assign ld_byte_o[SEL_MODE] = (st_q == ST_MODE);
  assign ld_byte_o[SEL_PORT] = (st_q == ST_PORT);
  assign ld_byte_o[SEL_FMT]  = (st_q == ST_FMT);
  assign ld_div_o            = (st_q == ST_DIV);
  assign busy_o              = (st_q != ST_IDLE);
endmodule

// File: rtl/lcfg_live_regs.sv
module lcfg_live_regs
  import lcfg_pkg::*;
#(
  parameter int unsigned REG_W = 8,
  parameter int unsigned DIV_W = 10,
  localparam int unsigned HI_W  = DIV_W - REG_W,
  localparam int unsigned LOW_W = REG_W - HI_W
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic [NUM_BYTE_REGS-1:0]            ld_byte_i,
  input  logic [NUM_BYTE_REGS-1:0][REG_W-1:0] stg_byte_i,
  input  logic                                ld_div_i,
  input  logic [DIV_W-1:0]                    stg_div_i,
  input  logic                                ctl2_wr_i,
  input  logic [LOW_W-1:0]                    ctl2_low_i,
  output logic [NUM_BYTE_REGS-1:0][REG_W-1:0] live_byte_o,
  output logic [REG_W-1:0]                    baud_o,
  output logic [REG_W-1:0]                    ctl2_o
);
  for (genvar g = 0; g < NUM_BYTE_REGS; g++) begin : g_live
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           live_byte_o[g] <= '0;
      else if (ld_byte_i[g]) live_byte_o[g] <= stg_byte_i[g];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       baud_o <= '0;
    else if (ld_div_i) baud_o <= stg_div_i[REG_W-1:0];
  end

  // read-modify-write: each field has its own writer
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl2_o <= '0;
    end else begin
      if (ld_div_i)  ctl2_o[REG_W-1:LOW_W] <= stg_div_i[DIV_W-1:REG_W];
      if (ctl2_wr_i) ctl2_o[LOW_W-1:0]     <= ctl2_low_i;
    end
  end
endmodule

// File: rtl/linecfg_defer.sv
module linecfg_defer
  import lcfg_pkg::*;
#(
  parameter int unsigned REG_W   = 8,
  parameter int unsigned DIV_W   = 10,
  parameter int unsigned BRK_BIT = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [2:0]       wr_sel_i,
  input  logic [DIV_W-1:0] wr_data_i,
  input  logic             brk_wr_i,
  input  logic             brk_val_i,
  input  logic             tx_idle_i,
  output logic [REG_W-1:0] mode_o,
  output logic [REG_W-1:0] port_o,
  output logic [REG_W-1:0] fmt_o,
  output logic [REG_W-1:0] baud_o,
  output logic [REG_W-1:0] ctl2_o,
  output logic             pending_o,
  output logic             busy_o
);
  localparam int unsigned HI_W  = DIV_W - REG_W;
  localparam int unsigned LOW_W = REG_W - HI_W;

  logic [NUM_BYTE_REGS-1:0][REG_W-1:0] sh_byte, stg_byte, live_byte;
  logic [DIV_W-1:0]                    sh_div, stg_div;
  logic [NUM_BYTE_REGS-1:0]            ld_byte;
  logic                                ld_div, pend, commit_start, ctl2_wr;

  assign ctl2_wr = wr_en_i && (wr_sel_i == SEL_CTL2);

  lcfg_shadow_bank #(.REG_W(REG_W), .DIV_W(DIV_W), .BRK_BIT(BRK_BIT)) u_shadow (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .wr_en_i        (wr_en_i),
    .wr_sel_i       (wr_sel_i),
    .wr_data_i      (wr_data_i),
    .brk_wr_i       (brk_wr_i),
    .brk_val_i      (brk_val_i),
    .commit_start_i (commit_start),
    .sh_byte_o      (sh_byte),
    .sh_div_o       (sh_div),
    .pend_o         (pend)
  );

  lcfg_commit_seq #(.REG_W(REG_W), .DIV_W(DIV_W)) u_seq (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .pend_i         (pend),
    .tx_idle_i      (tx_idle_i),
    .sh_byte_i      (sh_byte),
    .sh_div_i       (sh_div),
    .commit_start_o (commit_start),
    .ld_byte_o      (ld_byte),
    .ld_div_o       (ld_div),
    .stg_byte_o     (stg_byte),
    .stg_div_o      (stg_div),
    .busy_o         (busy_o)
  );

  lcfg_live_regs #(.REG_W(REG_W), .DIV_W(DIV_W)) u_live (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ld_byte_i   (ld_byte),
    .stg_byte_i  (stg_byte),
    .ld_div_i    (ld_div),
    .stg_div_i   (stg_div),
    .ctl2_wr_i   (ctl2_wr),
    .ctl2_low_i  (wr_data_i[LOW_W-1:0]),
    .live_byte_o (live_byte),
    .baud_o      (baud_o),
    .ctl2_o      (ctl2_o)
  );

  assign mode_o    = live_byte[SEL_MODE];
  assign port_o    = live_byte[SEL_PORT];
  assign fmt_o     = live_byte[SEL_FMT];
  assign pending_o = pend;
endmodule

// File: rtl/linecfg_defer_chk.sv
module linecfg_defer_chk #(
  parameter int unsigned REG_W = 8,
  parameter int unsigned DIV_W = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [2:0]       wr_sel_i,
  input logic             brk_wr_i,
  input logic             tx_idle_i,
  input logic [REG_W-1:0] mode_o,
  input logic [REG_W-1:0] port_o,
  input logic [REG_W-1:0] fmt_o,
  input logic [REG_W-1:0] baud_o,
  input logic [REG_W-1:0] ctl2_o,
  input logic             pending_o,
  input logic             busy_o
);
  localparam int unsigned LOW_W = REG_W - (DIV_W - REG_W);

  logic defer_wr, low_wr;
  assign defer_wr = (wr_en_i && (wr_sel_i <= 3'd3)) || brk_wr_i;
  assign low_wr   = wr_en_i && (wr_sel_i == 3'd4);

  p_write_pends_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    defer_wr |=> pending_o);

  p_start_clears_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && pending_o && tx_idle_i && !defer_wr) |=> (busy_o && !pending_o));

  p_start_cond_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(pending_o && tx_idle_i));

  p_live_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |=> ($stable(mode_o) && $stable(port_o) && $stable(fmt_o) && $stable(baud_o)));

  p_div_hi_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |=> $stable(ctl2_o[REG_W-1:LOW_W]));

  p_low_only_host_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !low_wr |=> $stable(ctl2_o[LOW_W-1:0]));

  p_rearm_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && defer_wr) |=> pending_o);
endmodule

bind linecfg_defer linecfg_defer_chk #(.REG_W(REG_W), .DIV_W(DIV_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .wr_sel_i  (wr_sel_i),
  .brk_wr_i  (brk_wr_i),
  .tx_idle_i (tx_idle_i),
  .mode_o    (mode_o),
  .port_o    (port_o),
  .fmt_o     (fmt_o),
  .baud_o    (baud_o),
  .ctl2_o    (ctl2_o),
  .pending_o (pending_o),
  .busy_o    (busy_o)
);

// File: tb/linecfg_defer_tb.sv
module linecfg_defer_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_sel = '0;
  logic [9:0] wr_data = '0;
  logic       brk_wr = 1'b0;
  logic       brk_val = 1'b0;
  logic       tx_idle = 1'b0;
  logic [7:0] mode, port, fmt, baud, ctl2;
  logic       pending, busy;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  linecfg_defer u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .brk_wr_i(brk_wr), .brk_val_i(brk_val),
    .tx_idle_i(tx_idle), .mode_o(mode), .port_o(port), .fmt_o(fmt),
    .baud_o(baud), .ctl2_o(ctl2), .pending_o(pending), .busy_o(busy)
  );

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // starts and ends at a falling edge
  task automatic do_wr(logic [2:0] sel, logic [9:0] data);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic settle();
    for (int i = 0; i < 40 && (busy || pending); i++) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 mode", 16'(mode), 16'h00);
    chk("R1 port", 16'(port), 16'h00);
    chk("R1 fmt", 16'(fmt), 16'h00);
    chk("R1 baud", 16'(baud), 16'h00);
    chk("R1 ctl2", 16'(ctl2), 16'h00);
    chk("R1 flags", 16'({pending, busy}), 16'h0);
  endtask

  task automatic t_hold_order();
    tx_idle = 1'b0;
    do_wr(3'd0, 10'h0A5);
    do_wr(3'd1, 10'h03C);
    do_wr(3'd2, 10'h081);
    do_wr(3'd3, 10'h2F7);
    do_wr(3'd0, 10'h05A);
    chk("R2 pending", 16'(pending), 16'h1);
    repeat (5) @(negedge clk);
    chk("R10 no start", 16'(busy), 16'h0);
    chk("R10 mode hold", 16'(mode), 16'h00);
    chk("R2 fmt hold", 16'(fmt), 16'h00);
    tx_idle = 1'b1;
    @(negedge clk);
    chk("R3 busy", 16'(busy), 16'h1);
    chk("R3 pend clr", 16'(pending), 16'h0);
    @(negedge clk);
    chk("R8 mode latest", 16'(mode), 16'h5A);
    chk("R4 port not yet", 16'(port), 16'h00);
    @(negedge clk);
    chk("R4 port", 16'(port), 16'h3C);
    chk("R4 fmt not yet", 16'(fmt), 16'h00);
    @(negedge clk);
    chk("R4 fmt", 16'(fmt), 16'h81);
    chk("R4 baud not yet", 16'(baud), 16'h00);
    chk("R4 still busy", 16'(busy), 16'h1);
    @(negedge clk);
    chk("R5 baud", 16'(baud), 16'hF7);
    chk("R5 ctl2", 16'(ctl2), 16'h80);
    chk("R4 busy end", 16'(busy), 16'h0);
  endtask

  task automatic t_ctl2();
    do_wr(3'd4, 10'h3D5);
    chk("R6 ctl2 direct", 16'(ctl2), 16'h95);
    chk("R6 no pend", 16'(pending), 16'h0);
    do_wr(3'd3, 10'h1AB);
    settle();
    chk("R5 baud2", 16'(baud), 16'hAB);
    chk("R5 ctl2 rmw", 16'(ctl2), 16'h55);
  endtask

  task automatic t_immediate();
    do_wr(3'd1, 10'h077);
    chk("R3 pend now", 16'({pending, busy}), 16'h2);
    @(negedge clk);
    chk("R3 started", 16'({pending, busy}), 16'h1);
    settle();
    chk("R3 port", 16'(port), 16'h77);
  endtask

  task automatic t_break();
    tx_idle = 1'b0;
    wr_en = 1'b1; wr_sel = 3'd2; wr_data = 10'h003; brk_wr = 1'b1; brk_val = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; brk_wr = 1'b0;
    chk("R7 pend", 16'(pending), 16'h1);
    chk("R7 fmt held", 16'(fmt), 16'h81);
    tx_idle = 1'b1;
    @(negedge clk);
    settle();
    chk("R7 override", 16'(fmt), 16'h43);
    tx_idle = 1'b0;
    brk_wr = 1'b1; brk_val = 1'b0;
    @(negedge clk);
    brk_wr = 1'b0;
    repeat (3) @(negedge clk);
    chk("R7 brk pend", 16'(pending), 16'h1);
    chk("R7 brk deferred", 16'(fmt), 16'h43);
    tx_idle = 1'b1;
    @(negedge clk);
    settle();
    chk("R7 brk clear", 16'(fmt), 16'h03);
  endtask

  task automatic t_collide();
    do_wr(3'd0, 10'h011);
    do_wr(3'd0, 10'h022);
    chk("R9 start rearm", 16'({pending, busy}), 16'h3);
    @(negedge clk);
    chk("R9 old snapshot", 16'(mode), 16'h11);
    do_wr(3'd1, 10'h099);
    chk("R9 port old", 16'(port), 16'h77);
    for (int i = 0; i < 10 && busy; i++) @(negedge clk);
    chk("R9 pend after", 16'({pending, busy}), 16'h2);
    chk("R9 mode first", 16'(mode), 16'h11);
    settle();
    chk("R9 mode second", 16'(mode), 16'h22);
    chk("R9 port second", 16'(port), 16'h99);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_hold_order();
    t_ctl2();
    t_immediate();
    t_break();
    t_collide();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule